// File: doc/BRIEF.md
# Logic and Shift Execution Unit

This block is the combinational datapath that executes the register-register Boolean and shift sub-groups of a 32-bit-word instruction set. The issue stage presents a 12-bit extended opcode and two source operands. Operand `b` is the left operand or the value being shifted. Operand `c` is the second Boolean input or the shift count. The unit returns the destination value in the same cycle. Register access, fetch, arithmetic and the memory sub-codes that share the same major group are handled elsewhere.

Ten two-input Boolean functions are decoded. They include the four implication and non-implication forms. Eight shift and rotate variants are decoded, including shifts that fill vacated bit positions with ones in either direction. Any extended opcode outside the two decoded windows raises `illegal` and forces the result to zero, so a trap handler downstream never sees a stale value. The operand width is the parameter `DATA_W`, which must be a power of two, at least 8.

The block has no state. The naming and layout follow the enumerated-decode style: a decoder resolves the opcode into a group enum (`GRP_NONE`, `GRP_BOOL`, `GRP_SHIFT`) and a function enum, and a single output process selects among the group results.

Top module: `bitops_xu`

## Requirements
- R1: Sub-codes 0x020, 0x021 and 0x022 give `b & c`, `b | c` and `b ^ c`.
- R2: Sub-codes 0x023, 0x024 and 0x025 give the bitwise complements of AND, OR and XOR of `b` and `c`.
- R3: Sub-code 0x026 gives `~b & c`, 0x027 gives `b & ~c`, 0x028 gives `~b | c`, and 0x029 gives `b | ~c`.
- R4: Sub-codes 0x030 and 0x032 both shift `b` left by `c`, and the freed low bits become 0.
- R5: Sub-code 0x031 shifts `b` right by `c` and copies bit `DATA_W-1` of `b` into the freed high bits; 0x033 does the same right shift with 0 fill.
- R6: Sub-code 0x034 shifts left and 0x035 shifts right, and every freed bit becomes 1.
- R7: Sub-code 0x036 rotates `b` left and 0x037 rotates it right, by `c` modulo `DATA_W`.
- R8: For every non-rotate shift, a count of `DATA_W` or more saturates the result: all zeros for 0x030, 0x032 and 0x033, all ones for 0x034 and 0x035, and all copies of bit `DATA_W-1` of `b` for 0x031.
- R9: Sub-codes 0x02A to 0x02F set `illegal` to 1 and `result` to 0.
- R10: Every other sub-code outside 0x020–0x029 and 0x030–0x037 sets `illegal` to 1 and `result` to 0. This includes the upper half of the shift window (0x038–0x03F) and every code whose upper eight bits are neither 0x02 nor 0x03.
- R11: Every sub-code in 0x020–0x029 or 0x030–0x037 holds `illegal` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sub_op | input | 12 | Extended opcode; bits 11:4 pick the group, bits 3:0 pick the function |
| opnd_b | input | DATA_W | Left operand, or the value to be shifted |
| opnd_c | input | DATA_W | Second Boolean operand, or the shift count |
| result | output | DATA_W | Destination value; zero when the opcode is not decoded |
| illegal | output | 1 | High when the sub-code is reserved or outside both groups |

## Verification
Two of the block's functions coincide whenever a shift count reaches or exceeds the word width. The same count must saturate the zero-fill, ones-fill and arithmetic shifts, and wrap the rotates modulo the width. The bench provokes this by sending counts of 0, 1, `DATA_W-1`, `DATA_W`, `DATA_W+5` and all ones to every shift sub-code, one after another. A behavioural model built from per-bit loops then judges each result: it expects a fill pattern for the shifts and a wrapped copy of `b` for the rotates. The illegal decode and the zeroing of the result also fall in the same cycle. Both outputs are compared together on each reserved and out-of-group code.

// File: rtl/bitops_xu_pkg.sv
package bitops_xu_pkg;

    // Group selected by bits 11:4 of the extended opcode
    localparam logic [7:0] OP_GRP_BOOL  = 8'h02;
    localparam logic [7:0] OP_GRP_SHIFT = 8'h03;
    // Highest defined function code inside the Boolean group
    localparam logic [3:0] BOOL_LAST    = 4'd9;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_BOOL  = 2'd1,
        GRP_SHIFT = 2'd2
    } grp_e;

    // Order matches the low nibble of the Boolean sub-codes
    typedef enum logic [3:0] {
        BF_AND      = 4'd0,
        BF_OR       = 4'd1,
        BF_XOR      = 4'd2,
        BF_NAND     = 4'd3,
        BF_NOR      = 4'd4,
        BF_XNOR     = 4'd5,
        BF_NB_AND_C = 4'd6,
        BF_B_AND_NC = 4'd7,
        BF_NB_OR_C  = 4'd8,
        BF_B_OR_NC  = 4'd9
    } boolfn_e;

    // Order matches the low three bits of the shift sub-codes
    typedef enum logic [2:0] {
        SH_ALEFT  = 3'd0,
        SH_ARIGHT = 3'd1,
        SH_ZLEFT  = 3'd2,
        SH_ZRIGHT = 3'd3,
        SH_OLEFT  = 3'd4,
        SH_ORIGHT = 3'd5,
        SH_ROTL   = 3'd6,
        SH_ROTR   = 3'd7
    } shfn_e;

    typedef struct packed {
        grp_e    grp;
        boolfn_e bfn;
        shfn_e   sfn;
    } dec_t;

endpackage

// File: rtl/bitops_xu_dec.sv
module bitops_xu_dec
    import bitops_xu_pkg::*;
(
    input  logic [11:0] sub_op,
    output dec_t        dec
);

    always_comb begin
        dec.grp = GRP_NONE;
        dec.bfn = BF_AND;
        dec.sfn = SH_ALEFT;
        unique case (sub_op[11:4])
            OP_GRP_BOOL: begin
                if (sub_op[3:0] <= BOOL_LAST) begin
                    dec.grp = GRP_BOOL;
                    dec.bfn = boolfn_e'(sub_op[3:0]);
                end
            end
            OP_GRP_SHIFT: begin
                if (!sub_op[3]) begin
                    dec.grp = GRP_SHIFT;
                    dec.sfn = shfn_e'(sub_op[2:0]);
                end
            end
            default: begin
                dec.grp = GRP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/bitops_xu_bool.sv
module bitops_xu_bool
    import bitops_xu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  boolfn_e           fn,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (fn)
            BF_AND:      y = b & c;
            BF_OR:       y = b | c;
            BF_XOR:      y = b ^ c;
            BF_NAND:     y = ~(b & c);
            BF_NOR:      y = ~(b | c);
            BF_XNOR:     y = ~(b ^ c);
            BF_NB_AND_C: y = ~b & c;
            BF_B_AND_NC: y = b & ~c;
            BF_NB_OR_C:  y = ~b | c;
            BF_B_OR_NC:  y = b | ~c;
            default:     y = '0;
        endcase
    end

endmodule

// File: rtl/bitops_xu_barrel.sv
// Logarithmic right shifter: each stage moves by a power of two and
// either brings in the fill bit or wraps the bits that drop out.
module bitops_xu_barrel #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  amt,
    input  logic              fill,
    input  logic              wrap,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stg [CNT_W+1];

    assign stg[0] = din;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        logic [DATA_W-1:0] moved;
        assign moved = wrap ? {stg[s][DIST-1:0], stg[s][DATA_W-1:DIST]}
                            : {{DIST{fill}}, stg[s][DATA_W-1:DIST]};
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign dout = stg[CNT_W];

endmodule

// File: rtl/bitops_xu_shift.sv
module bitops_xu_shift
    import bitops_xu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shfn_e             fn,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);

    localparam int                CNT_W   = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] WIDTH_V = DATA_W'(DATA_W);

    logic              go_left;
    logic              wrap;
    logic              fill;
    logic              in_range;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] post;
    logic [DATA_W-1:0] aligned;

    function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    always_comb begin
        go_left = 1'b0;
        wrap    = 1'b0;
        fill    = 1'b0;
        unique case (fn)
            SH_ALEFT:  go_left = 1'b1;
            SH_ARIGHT: fill    = b[DATA_W-1];
            SH_ZLEFT:  go_left = 1'b1;
            SH_ZRIGHT: fill    = 1'b0;
            SH_OLEFT: begin
                go_left = 1'b1;
                fill    = 1'b1;
            end
            SH_ORIGHT: fill    = 1'b1;
            SH_ROTL: begin
                go_left = 1'b1;
                wrap    = 1'b1;
            end
            SH_ROTR:   wrap    = 1'b1;
            default:   fill    = 1'b0;
        endcase
    end

    assign in_range = (c < WIDTH_V);
    assign pre      = go_left ? flip(b) : b;

    bitops_xu_barrel #(
        .DATA_W(DATA_W)
    ) i_barrel (
        .din  (pre),
        .amt  (c[CNT_W-1:0]),
        .fill (fill),
        .wrap (wrap),
        .dout (post)
    );

    assign aligned = go_left ? flip(post) : post;
    assign y       = (in_range || wrap) ? aligned : {DATA_W{fill}};

endmodule

// File: rtl/bitops_xu.sv
module bitops_xu
    import bitops_xu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [11:0]       sub_op,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    dec_t              dec;
    logic [DATA_W-1:0] bool_y;
    logic [DATA_W-1:0] shift_y;

    bitops_xu_dec i_dec (
        .sub_op (sub_op),
        .dec    (dec)
    );

    bitops_xu_bool #(
        .DATA_W(DATA_W)
    ) i_bool (
        .fn (dec.bfn),
        .b  (opnd_b),
        .c  (opnd_c),
        .y  (bool_y)
    );

    bitops_xu_shift #(
        .DATA_W(DATA_W)
    ) i_shift (
        .fn (dec.sfn),
        .b  (opnd_b),
        .c  (opnd_c),
        .y  (shift_y)
    );

    always_comb begin
        illegal = 1'b0;
        unique case (dec.grp)
            GRP_BOOL:  result = bool_y;
            GRP_SHIFT: result = shift_y;
            GRP_NONE: begin
                result  = '0;
                illegal = 1'b1;
            end
            default: begin
                result  = '0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bitops_xu_chk.sv
module bitops_xu_chk #(
    parameter int DATA_W = 32
) (
    input logic [11:0]       sub_op,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] opnd_c,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);

    localparam logic [DATA_W-1:0] WIDTH_V = DATA_W'(DATA_W);

    logic legal_code;
    assign legal_code = (sub_op >= 12'h020 && sub_op <= 12'h029) ||
                        (sub_op >= 12'h030 && sub_op <= 12'h037);

    always_comb begin
        // R9: reserved Boolean codes trap with a zero result
        if (sub_op >= 12'h02A && sub_op <= 12'h02F) begin
            p_reserved_trap_r9: assert (illegal && result == '0)
                else $error("reserved code not trapped");
        end
        // R10: a trapped code never leaks a value
        if (illegal) begin
            p_trap_zero_r10: assert (result == '0)
                else $error("illegal with nonzero result");
        end
        // R11: decoded codes never trap
        if (legal_code) begin
            p_legal_quiet_r11: assert (!illegal)
                else $error("decoded code flagged illegal");
        end
        // R8: zero-fill shifts saturate to zero
        if ((sub_op == 12'h032 || sub_op == 12'h033) && opnd_c >= WIDTH_V) begin
            p_sat_zero_r8: assert (result == '0)
                else $error("zero-fill saturation");
        end
        // R8: ones-fill shifts saturate to all ones
        if ((sub_op == 12'h034 || sub_op == 12'h035) && opnd_c >= WIDTH_V) begin
            p_sat_ones_r8: assert (&result)
                else $error("ones-fill saturation");
        end
        // R7: rotating by the full width returns the operand
        if ((sub_op == 12'h036 || sub_op == 12'h037) && opnd_c == WIDTH_V) begin
            p_rot_full_r7: assert (result == opnd_b)
                else $error("full-width rotate");
        end
        // R2: NAND is the complement of AND
        if (sub_op == 12'h023) begin
            p_nand_r2: assert (result == ~(opnd_b & opnd_c))
                else $error("nand");
        end
    end

endmodule

bind bitops_xu bitops_xu_chk #(
    .DATA_W(DATA_W)
) i_chk (
    .sub_op  (sub_op),
    .opnd_b  (opnd_b),
    .opnd_c  (opnd_c),
    .result  (result),
    .illegal (illegal)
);

// File: tb/test_bitops_xu.sv
`timescale 1ns/1ps
module test_bitops_xu;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  sub_op = 12'h000;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] opnd_c = '0;
    logic [W-1:0] result;
    logic         illegal;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bitops_xu #(.DATA_W(W)) i_bitops_xu (
        .sub_op  (sub_op),
        .opnd_b  (opnd_b),
        .opnd_c  (opnd_c),
        .result  (result),
        .illegal (illegal)
    );

    // Behavioural reference, written bit by bit from the requirements
    function automatic void ref_calc(input logic [11:0] op, input logic [W-1:0] b,
                                     input logic [W-1:0] c, output logic [W-1:0] y,
                                     output logic bad);
        longint cnt;
        longint n;
        longint nr;
        logic   f;
        cnt = longint'({32'd0, c});
        n   = (cnt >= W) ? W : cnt;
        nr  = cnt % W;
        y   = '0;
        bad = 1'b0;
        case (op)
            12'h020: y = b & c;
            12'h021: y = b | c;
            12'h022: y = b ^ c;
            12'h023: y = ~(b & c);
            12'h024: y = ~(b | c);
            12'h025: y = ~(b ^ c);
            12'h026: y = ~b & c;
            12'h027: y = b & ~c;
            12'h028: y = ~b | c;
            12'h029: y = b | ~c;
            12'h030, 12'h032, 12'h034: begin
                f = (op == 12'h034);
                for (int i = 0; i < W; i++) y[i] = (i >= n) ? b[i - n] : f;
            end
            12'h031, 12'h033, 12'h035: begin
                f = (op == 12'h031) ? b[W-1] : (op == 12'h035);
                for (int i = 0; i < W; i++) y[i] = (i + n < W) ? b[i + n] : f;
            end
            12'h036: for (int i = 0; i < W; i++) y[i] = b[(i - nr + W) % W];
            12'h037: for (int i = 0; i < W; i++) y[i] = b[(i + nr) % W];
            default: bad = 1'b1;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] op, input logic [W-1:0] c);
        if (op >= 12'h020 && op <= 12'h022) return "R1";
        if (op >= 12'h023 && op <= 12'h025) return "R2";
        if (op >= 12'h026 && op <= 12'h029) return "R3";
        if (op >= 12'h02A && op <= 12'h02F) return "R9";
        if (op >= 12'h030 && op <= 12'h035 && c >= W) return "R8";
        if (op == 12'h030 || op == 12'h032) return "R4";
        if (op == 12'h031 || op == 12'h033) return "R5";
        if (op == 12'h034 || op == 12'h035) return "R6";
        if (op == 12'h036 || op == 12'h037) return "R7";
        return "R10";
    endfunction

    task automatic compare(input string tag);
        logic [W-1:0] ey;
        logic         eb;
        ref_calc(sub_op, opnd_b, opnd_c, ey, eb);
        n_checks++;
        if (result !== ey) begin
            n_fails++;
            $display("FAIL %s result op=%03h b=%08h c=%08h got %08h exp %08h",
                     tag, sub_op, opnd_b, opnd_c, result, ey);
        end
        n_checks++;
        if (illegal !== eb) begin
            n_fails++;
            $display("FAIL %s illegal op=%03h got %0b exp %0b",
                     eb ? tag : "R11", sub_op, illegal, eb);
        end
    endtask

    task automatic run_vec(input logic [11:0] op, input logic [W-1:0] b, input logic [W-1:0] c);
        @(negedge clk);
        sub_op = op;
        opnd_b = b;
        opnd_c = c;
        @(posedge clk);
        #1;
        compare(tag_of(op, c));
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] counts [6];
        counts[0] = 0;
        counts[1] = 1;
        counts[2] = W - 1;
        counts[3] = W;
        counts[4] = W + 5;
        counts[5] = '1;

        repeat (3) @(posedge clk);
        #1;
        // Reset state: code 0x000 is outside both groups (R10)
        compare("R10");
        rst_n = 1'b1;

        // R1 R2 R3: all Boolean functions over several operand patterns
        for (int op = 12'h020; op <= 12'h029; op++) begin
            run_vec(12'(op), 32'hF0F0_CC33, 32'hFF00_AA55);
            run_vec(12'(op), 32'h0000_0000, 32'hFFFF_FFFF);
            run_vec(12'(op), 32'h1234_5678, 32'h1234_5678);
        end

        // R4 R5 R6 R7 R8: every shift code at boundary counts, with both sign values
        for (int op = 12'h030; op <= 12'h037; op++) begin
            for (int k = 0; k < 6; k++) begin
                run_vec(12'(op), 32'h8765_4321, counts[k]);
                run_vec(12'(op), 32'h3C5A_0F96, counts[k]);
            end
        end

        // R9: the reserved Boolean codes
        for (int op = 12'h02A; op <= 12'h02F; op++) run_vec(12'(op), 32'hFFFF_FFFF, 32'h0000_0001);

        // R10: upper half of the shift window and foreign groups
        for (int op = 12'h038; op <= 12'h03F; op++) run_vec(12'(op), 32'hDEAD_BEEF, 32'h4);
        run_vec(12'h120, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_vec(12'hF23, 32'hFFFF_FFFF, 32'h0);
        run_vec(12'h040, 32'hA5A5_A5A5, 32'h3);
        run_vec(12'h01F, 32'h1, 32'h1);

        // Mixed traffic across the windows and their neighbours
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] op;
            logic [W-1:0] cc;
            op = (i % 4 == 0) ? 12'($urandom) : 12'(12'h018 + ($urandom % 40));
            cc = (i % 3 == 0) ? W'($urandom % 70) : W'($urandom);
            run_vec(op, W'($urandom), cc);
        end

        finish_run();
    end

endmodule